// File: doc/BRIEF.md
# Ticket Lock Arbiter

This block is a single hardware lock shared by a set of requesters. Its state is a pair of counters: a dispenser that hands out ticket numbers, and a serving counter that says which ticket may hold the lock right now. A requester pulses its acquire line for one cycle and is given the current dispenser value as its ticket. The dispenser then advances by one, so each acquire costs exactly one fetch-and-increment. The requester waits until its grant line rises, which happens when the serving counter reaches its ticket. It then works in its critical section and pulses its release line, which advances the serving counter and passes the lock to the next ticket.

Because tickets are issued in arrival order and served in numeric order, the lock is granted first-come first-served without any retry traffic. Acquires that arrive in the same cycle are ordered by requester index. Both counters wrap around their width, and every comparison is made within that width. A release from a requester that does not hold the lock changes nothing but raises an error flag that stays set until reset. A requester that already owns a ticket cannot take a second one.

Top module: `ticket_lock_arb`

## Requirements
- R1: After synchronous active-low reset no grant is asserted, the error flag is low, both counters are zero, and the first ticket issued is 0.
- R2: An accepted acquire pulse in cycle k makes that requester's ticket output equal to the dispenser value in the cycle after k. The dispenser then advances by one for each accepted acquire.
- R3: A requester's grant is high exactly when it owns a ticket equal to the serving counter. At most one grant is high at a time. A grant stays high with a stable ticket until its owner releases.
- R4: A release from the grant holder advances the serving counter by one. The holder's grant drops in the following cycle, and the grant passes to the owner of the next ticket, if any.
- R5: Grants are given in the order in which the acquires were accepted.
- R6: Acquires accepted in the same cycle receive consecutive tickets, with the lowest requester index taking the lowest ticket.
- R7: A release from a requester that does not hold the grant leaves the serving counter unchanged. It sets the error flag, which stays high until reset.
- R8: An acquire from a requester that already owns a ticket, whether waiting or granted, is ignored. Its ticket output is unchanged and the dispenser does not advance.
- R9: Both counters wrap modulo 2^TKT_W. Ticket issue and grant order stay correct across the wrap; for example, with TKT_W=3, ticket 0 follows ticket 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acq_i | input | N_REQ | One-cycle acquire pulse per requester |
| rel_i | input | N_REQ | One-cycle release pulse per requester |
| grant_o | output | N_REQ | Lock held, one bit per requester |
| ticket_o | output | N_REQ*TKT_W | Last ticket issued to each requester; requester i uses bits [i*TKT_W +: TKT_W] |
| rel_err_o | output | 1 | Sticky flag for a release from a non-holder |

## Verification
A serving counter that skipped or stalled would be seen in the cycle after a release. Either the grant would land on the wrong requester, or no grant would be high while a waiter is queued. A dispenser that double-issued or skipped a value would show as two equal ticket outputs or a gap in the next grant order. A slot that lost its queued state would make a grant disappear early. The vector walk compares the full grant vector and error flag after every cycle, and the directed tests compare the ticket values, so each of these faults is reported within one cycle of its cause.

// File: rtl/tlk_pkg.sv
// Shared definitions for the ticket lock arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package tlk_pkg;
    // Occupancy of a requester slot: no ticket, or a ticket in the queue.
    typedef enum logic {
        SLOT_EMPTY  = 1'b0,
        SLOT_QUEUED = 1'b1
    } slot_phase_e;
endpackage

// File: rtl/tlk_dispenser.sv
// Ticket dispenser: holds the next-ticket counter and gives consecutive
// values to the acquires accepted this cycle, lowest index first.
// Assumes: take_i contains only acquires from slots without a ticket.
module tlk_dispenser #(
    parameter int N_REQ = 4,
    parameter int TKT_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_REQ-1:0]               take_i,
    output logic [N_REQ-1:0][TKT_W-1:0]    tkt_o
);
    logic [TKT_W-1:0] next_q;
    logic [TKT_W-1:0] next_d;

    // Walk the requesters in index order and hand out running values.
    always_comb begin
        logic [TKT_W-1:0] run;
        run = next_q;
        for (int i = 0; i < N_REQ; i++) begin
            tkt_o[i] = run;
            if (take_i[i]) begin
                run = run + TKT_W'(1);
            end
        end
        next_d = run;
    end

    // Register the advanced next-ticket counter (wraps by width).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
        end else begin
            next_q <= next_d;
        end
    end
endmodule

// File: rtl/tlk_slot.sv
// Per-requester slot: stores the ticket, accepts an acquire only when empty,
// raises grant when its ticket equals the serving value, clears on release.
// Assumes: serving_i comes from the shared serving counter.
module tlk_slot #(
    parameter int TKT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_i,
    input  logic             rel_i,
    input  logic [TKT_W-1:0] tkt_in_i,
    input  logic [TKT_W-1:0] serving_i,
    output logic             take_o,
    output logic             grant_o,
    output logic             rel_ok_o,
    output logic             rel_bad_o,
    output logic [TKT_W-1:0] tkt_o
);
    import tlk_pkg::*;

    slot_phase_e      phase_q;
    logic [TKT_W-1:0] tkt_q;

    // Decode acquire acceptance, grant and release legality.
    always_comb begin
        take_o    = acq_i && (phase_q == SLOT_EMPTY);
        grant_o   = (phase_q == SLOT_QUEUED) && (tkt_q == serving_i);
        rel_ok_o  = rel_i && grant_o;
        rel_bad_o = rel_i && !grant_o;
    end

    // Hold slot phase and ticket across acquire and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= SLOT_EMPTY;
            tkt_q   <= '0;
        end else if (take_o) begin
            phase_q <= SLOT_QUEUED;
            tkt_q   <= tkt_in_i;
        end else if (rel_ok_o) begin
            phase_q <= SLOT_EMPTY;
        end
    end

    assign tkt_o = tkt_q;
endmodule

// File: rtl/tlk_server.sv
// Serving counter and release error flag. Advances by one on a legal
// release and records any release from a non-holder.
// Assumes: at most one bit of rel_ok_i is set (tickets are unique).
module tlk_server #(
    parameter int N_REQ = 4,
    parameter int TKT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] rel_ok_i,
    input  logic [N_REQ-1:0] rel_bad_i,
    output logic [TKT_W-1:0] serving_o,
    output logic             err_o
);
    logic [TKT_W-1:0] serving_q;
    logic             err_q;

    // Advance serving on a holder release; latch the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serving_q <= '0;
            err_q     <= 1'b0;
        end else begin
            if (|rel_ok_i) begin
                serving_q <= serving_q + TKT_W'(1);
            end
            if (|rel_bad_i) begin
                err_q <= 1'b1;
            end
        end
    end

    assign serving_o = serving_q;
    assign err_o     = err_q;
endmodule

// File: rtl/ticket_lock_arb.sv
// Ticket lock arbiter top: one lock shared by N_REQ requesters, granted in
// strict arrival order through a ticket dispenser and a serving counter.
// Assumes: acq_i and rel_i are synchronous to clk; TKT_W bits can name
// N_REQ distinct outstanding tickets.
module ticket_lock_arb #(
    parameter int N_REQ = 4,
    parameter int TKT_W = $clog2(N_REQ) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_REQ-1:0]         acq_i,
    input  logic [N_REQ-1:0]         rel_i,
    output logic [N_REQ-1:0]         grant_o,
    output logic [N_REQ*TKT_W-1:0]   ticket_o,
    output logic                     rel_err_o
);
    logic [N_REQ-1:0]             take;
    logic [N_REQ-1:0]             rel_ok;
    logic [N_REQ-1:0]             rel_bad;
    logic [N_REQ-1:0][TKT_W-1:0]  new_tkt;
    logic [TKT_W-1:0]             serving;

    tlk_dispenser #(.N_REQ(N_REQ), .TKT_W(TKT_W)) disp_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .tkt_o  (new_tkt)
    );

    for (genvar g = 0; g < N_REQ; g++) begin : g_slot
        tlk_slot #(.TKT_W(TKT_W)) slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .acq_i     (acq_i[g]),
            .rel_i     (rel_i[g]),
            .tkt_in_i  (new_tkt[g]),
            .serving_i (serving),
            .take_o    (take[g]),
            .grant_o   (grant_o[g]),
            .rel_ok_o  (rel_ok[g]),
            .rel_bad_o (rel_bad[g]),
            .tkt_o     (ticket_o[g*TKT_W +: TKT_W])
        );
    end

    tlk_server #(.N_REQ(N_REQ), .TKT_W(TKT_W)) serve_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rel_ok_i  (rel_ok),
        .rel_bad_i (rel_bad),
        .serving_o (serving),
        .err_o     (rel_err_o)
    );
endmodule

// File: rtl/ticket_lock_arb_chk.sv
// Port-level checker for the ticket lock arbiter, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module ticket_lock_arb_chk #(
    parameter int N_REQ = 4,
    parameter int TKT_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_REQ-1:0]       acq_i,
    input logic [N_REQ-1:0]       rel_i,
    input logic [N_REQ-1:0]       grant_o,
    input logic [N_REQ*TKT_W-1:0] ticket_o,
    input logic                   rel_err_o
);
    // R3: never two holders
    a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R4: a holder that releases loses its grant next cycle
    a_r4_release_drops_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rel_i & grant_o)) |=> ((grant_o & $past(rel_i & grant_o)) == '0));

    // R7: release from a non-holder raises the flag
    a_r7_bad_release_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rel_i & ~grant_o)) |=> rel_err_o);

    // R7: flag is sticky until reset
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err_o |=> rel_err_o);

    for (genvar g = 0; g < N_REQ; g++) begin : g_req
        // R3: a grant persists with a stable ticket until released
        a_r3_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_o[g] && !rel_i[g]) |=>
                (grant_o[g] && $stable(ticket_o[g*TKT_W +: TKT_W])));
    end
endmodule

bind ticket_lock_arb ticket_lock_arb_chk #(.N_REQ(N_REQ), .TKT_W(TKT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_i     (acq_i),
    .rel_i     (rel_i),
    .grant_o   (grant_o),
    .ticket_o  (ticket_o),
    .rel_err_o (rel_err_o)
);

// File: tb/ticket_lock_arb_tb_top.sv
`timescale 1ns/1ps
// Bench: vector walk of acquire/release patterns, then directed tests for
// reset, same-cycle ordering, wrap-around, ignored acquire and bad release.
module ticket_lock_arb_tb_top;
    localparam int N  = 4;
    localparam int TW = 3;
    localparam int NV = 11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    acq_i = '0;
    logic [N-1:0]    rel_i = '0;
    logic [N-1:0]    grant_o;
    logic [N*TW-1:0] ticket_o;
    logic            rel_err_o;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ticket_lock_arb #(.N_REQ(N), .TKT_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .rel_i(rel_i),
        .grant_o(grant_o), .ticket_o(ticket_o), .rel_err_o(rel_err_o)
    );

    // Fields: acq[12:9], rel[8:5], expected grant[4:1], expected err[0]
    localparam logic [12:0] VEC_TAB [0:NV-1] = '{
        {4'b0001, 4'b0000, 4'b0001, 1'b0},  // R2 first acquire granted at once
        {4'b0110, 4'b0000, 4'b0001, 1'b0},  // R6 two queue behind
        {4'b1000, 4'b0000, 4'b0001, 1'b0},  // R5 fourth queues
        {4'b0010, 4'b0000, 4'b0001, 1'b0},  // R8 repeat acquire ignored
        {4'b0000, 4'b0001, 4'b0010, 1'b0},  // R4 pass to ticket 1
        {4'b0000, 4'b0100, 4'b0010, 1'b1},  // R7 non-holder release
        {4'b0001, 4'b0000, 4'b0010, 1'b1},  // R5 requester 0 requeues
        {4'b0000, 4'b0010, 4'b0100, 1'b1},  // R5 ticket 2
        {4'b0000, 4'b0100, 4'b1000, 1'b1},  // R5 ticket 3
        {4'b0000, 4'b1000, 4'b0001, 1'b1},  // R5 ticket 4 (requester 0)
        {4'b0000, 4'b0001, 4'b0000, 1'b1}   // R4 queue empty
    };

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle of pulses; return 2 ns after the capturing edge.
    task automatic step(input logic [N-1:0] a, input logic [N-1:0] r);
        @(negedge clk);
        acq_i = a;
        rel_i = r;
        @(posedge clk);
        #2;
        acq_i = '0;
        rel_i = '0;
    endtask

    function automatic int tk(input int i);
        return int'(ticket_o[i*TW +: TW]);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        check("R1 grant after reset", int'(grant_o), 0);
        check("R1 err after reset", int'(rel_err_o), 0);

        for (int v = 0; v < NV; v++) begin
            step(VEC_TAB[v][12:9], VEC_TAB[v][8:5]);
            check($sformatf("R5 vec %0d grant", v), int'(grant_o), int'(VEC_TAB[v][4:1]));
            check($sformatf("R7 vec %0d err", v), int'(rel_err_o), int'(VEC_TAB[v][0]));
        end

        // R1: reset clears the sticky flag and counters
        do_reset();
        check("R1 err cleared", int'(rel_err_o), 0);
        check("R1 grant cleared", int'(grant_o), 0);

        // R6: same-cycle acquires get consecutive tickets by index
        step(4'b1111, 4'b0000);
        for (int i = 0; i < N; i++) check($sformatf("R6 ticket %0d", i), tk(i), i);
        check("R3 grant to ticket 0", int'(grant_o), 1);

        // R4/R5: releases hand over in ticket order
        step(4'b0000, 4'b0001); check("R4 grant to 1", int'(grant_o), 2);
        step(4'b0000, 4'b0010); check("R4 grant to 2", int'(grant_o), 4);
        step(4'b0000, 4'b0100); check("R4 grant to 3", int'(grant_o), 8);
        step(4'b0000, 4'b1000); check("R4 none left", int'(grant_o), 0);

        // R2/R9: uncontended cycles walk the counters toward the wrap
        for (int k = 0; k < 3; k++) begin
            step(4'b0001, 4'b0000);
            check("R2 ticket issued", tk(0), (4 + k) % 8);
            check("R2 granted", int'(grant_o), 1);
            step(4'b0000, 4'b0001);
            check("R4 released", int'(grant_o), 0);
        end

        // R9: tickets 7 and 0 straddle the wrap
        step(4'b0110, 4'b0000);
        check("R9 ticket 7", tk(1), 7);
        check("R9 ticket wraps to 0", tk(2), 0);
        check("R9 grant to 7", int'(grant_o), 2);
        step(4'b0000, 4'b0010);
        check("R9 grant after wrap", int'(grant_o), 4);
        step(4'b0000, 4'b0100);
        check("R9 drained", int'(grant_o), 0);

        // R8: repeat acquire ignored, dispenser not advanced
        step(4'b0001, 4'b0000);
        check("R2 ticket 1", tk(0), 1);
        step(4'b0010, 4'b0000);
        check("R2 ticket 2", tk(1), 2);
        step(4'b0010, 4'b0000);
        check("R8 ticket unchanged", tk(1), 2);
        step(4'b0001, 4'b0000);
        check("R8 holder ticket unchanged", tk(0), 1);
        step(4'b1000, 4'b0000);
        check("R8 dispenser not advanced", tk(3), 3);

        // R7: bad release ignored, flag set, serving not moved
        step(4'b0000, 4'b0100);
        check("R7 grant kept", int'(grant_o), 1);
        check("R7 err set", int'(rel_err_o), 1);
        step(4'b0000, 4'b0001);
        check("R7 serving moved once", int'(grant_o), 2);
        check("R7 err sticky", int'(rel_err_o), 1);

        finish_run();
    end
endmodule